// File: doc/BRIEF.md
# Four-bit ALU

This block is a purely combinational arithmetic logic unit for 4-bit data. It takes two operands, X and Y, a 4-bit function code and a single carry input. In the same cycle it returns a 4-bit result, a carry output, a zero flag and a negative flag. There are no registers inside it. The surrounding datapath registers whatever it needs.

The function code is wired straight from the opcode field of an instruction, so the codes below are fixed.

- The arithmetic group covers add, subtract, increment and decrement. All four run through one shared ripple adder, with the operands conditioned per code.
- The logic group covers XOR, AND and OR.
- A Y pass-through lets a register copy reuse the ALU path instead of needing a datapath of its own.
- The shift group does single-place right moves: arithmetic, logical, and rotate through the carry.

Top module: `alu4_core`

## Requirements
- R1: Code 0000 (add) gives result = (X + Y) mod 16 and carry = 1 exactly when X + Y > 15.
- R2: Code 0001 (subtract) gives result = (X - Y) mod 16 in two's complement, and carry = 1 exactly when X >= Y, meaning no borrow.
- R3: Code 0010 (increment) gives (X + 1) mod 16 with carry = 1 only for X = 1111. Code 0011 (decrement) gives (X - 1) mod 16 with carry = 1 whenever X is not 0000.
- R4: Codes 0100, 0101 and 0110 give the bitwise XOR, AND and OR of X and Y, each with carry 0.
- R5: Code 0111 (pass-through) gives result = Y unchanged, with carry 0.
- R6: Code 1000 (arithmetic right shift) gives {X[3], X[3:1]}, with carry = X[0].
- R7: Code 1001 (logical right shift) gives {0, X[3:1]}, with carry = X[0].
- R8: Code 1010 (rotate right through carry) gives {carry input, X[3:1]}, with carry = X[0].
- R9: Codes 1011 to 1111 give result 0000 and carry 0.
- R10: The zero flag is 1 exactly when the 4-bit result is 0000.
- R11: The negative flag equals bit 3 of the result.
- R12: The carry input has no effect on result or carry for every code except 1010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 4 | First operand (X) |
| y_i | input | 4 | Second operand (Y) |
| func_i | input | 4 | Function code from the instruction opcode field |
| carry_i | input | 1 | Carry input, used only by rotate |
| result_o | output | 4 | Result |
| carry_o | output | 1 | Carry output |
| zero_o | output | 1 | Result-is-zero flag |
| neg_o | output | 1 | Result bit 3 |

## Verification
Every one of the 16 codes is applied over all 256 operand pairs, once with the carry input low and once with it high.

- The sweep with the carry input high is judged separately from the low one. That separates the rotate, which must consume the carry, from every other code, which must ignore it.
- Directed vectors target the carry boundaries: 15+1, 0-0, 0-1, increment from 1111 and decrement from 0000. These catch a flipped borrow sense or an off-by-one carry-in on the shared adder.
- Shifts of operands with bit 3 set distinguish sign fill from zero fill from carry fill.
- The unused codes are driven with busy operands, so that any leakage from the adder or the logic unit shows up in the output.

// File: rtl/alu4_pkg.sv
`timescale 1ns/1ps
// alu4_pkg: function codes shared by the ALU units.
// Assumes the code is driven directly from a 4-bit opcode field.
package alu4_pkg;

    localparam int unsigned FUNC_W = 4;

    typedef enum logic [FUNC_W-1:0] {
        OP_ADD  = 4'b0000,
        OP_SUB  = 4'b0001,
        OP_INC  = 4'b0010,
        OP_DEC  = 4'b0011,
        OP_XOR  = 4'b0100,
        OP_AND  = 4'b0101,
        OP_OR   = 4'b0110,
        OP_PASS = 4'b0111,
        OP_ASR  = 4'b1000,
        OP_LSR  = 4'b1001,
        OP_RRC  = 4'b1010
    } alu_op_e;

    typedef enum logic [1:0] {
        UNIT_NONE  = 2'd0,
        UNIT_ARITH = 2'd1,
        UNIT_LOGIC = 2'd2,
        UNIT_SHIFT = 2'd3
    } alu_unit_e;

endpackage

// File: rtl/alu4_arith.sv
`timescale 1ns/1ps
// alu4_arith: add, subtract, increment and decrement on one ripple adder.
// The second adder operand and the adder carry-in are conditioned per code.
// Carry out means "no borrow" for subtract and decrement.
// Assumes op_i is an arithmetic code; other codes yield x_i + 0.
module alu4_arith
    import alu4_pkg::*;
#(
    parameter int unsigned DATA_W = 4
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o
);

    logic [DATA_W-1:0] opnd_b;
    logic              cin_add;
    logic [DATA_W:0]   carry;

    // Condition the second operand and carry-in for the selected code.
    always_comb begin
        opnd_b  = '0;
        cin_add = 1'b0;
        case (op_i)
            OP_ADD: begin opnd_b = y_i;  cin_add = 1'b0; end
            OP_SUB: begin opnd_b = ~y_i; cin_add = 1'b1; end
            OP_INC: begin opnd_b = '0;   cin_add = 1'b1; end
            OP_DEC: begin opnd_b = '1;   cin_add = 1'b0; end
            default: begin opnd_b = '0;  cin_add = 1'b0; end
        endcase
    end

    assign carry[0] = cin_add;

    // One full-adder cell per bit, rippling the carry upward.
    for (genvar i = 0; i < DATA_W; i++) begin : g_fa
        assign sum_o[i]   = x_i[i] ^ opnd_b[i] ^ carry[i];
        assign carry[i+1] = (x_i[i] & opnd_b[i]) | (carry[i] & (x_i[i] ^ opnd_b[i]));
    end

    assign cout_o = carry[DATA_W];

    // Check the borrow sense of subtract against a magnitude comparison.
    always_comb begin
        if (!$isunknown({op_i, x_i, y_i}) && op_i == OP_SUB) begin
            assert_sub_noborrow_R2: assert (cout_o == (x_i >= y_i))
                else $error("R2 subtract carry disagrees with X>=Y");
        end
    end

    // Check that increment carries only out of the all-ones value.
    always_comb begin
        if (!$isunknown({op_i, x_i}) && op_i == OP_INC) begin
            assert_inc_carry_R3: assert (cout_o == (x_i == '1))
                else $error("R3 increment carry wrong");
        end
    end

endmodule

// File: rtl/alu4_logic.sv
`timescale 1ns/1ps
// alu4_logic: bitwise XOR, AND, OR and the Y pass-through used for copies.
// Assumes op_i is a logic code; other codes yield zero. Never produces a carry.
module alu4_logic
    import alu4_pkg::*;
#(
    parameter int unsigned DATA_W = 4
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    output logic [DATA_W-1:0] res_o
);

    // Select the bitwise function for the current code.
    always_comb begin
        case (op_i)
            OP_XOR:  res_o = x_i ^ y_i;
            OP_AND:  res_o = x_i & y_i;
            OP_OR:   res_o = x_i | y_i;
            OP_PASS: res_o = y_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu4_shift.sv
`timescale 1ns/1ps
// alu4_shift: single-place right moves (arithmetic, logical, rotate through carry).
// Only the fill bit differs between the three; bit 0 always leaves as carry.
// Assumes op_i is a shift code; other codes yield zero with no carry.
module alu4_shift
    import alu4_pkg::*;
#(
    parameter int unsigned DATA_W = 4
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);

    logic fill;
    logic active;

    // Choose the bit that enters at the top.
    always_comb begin
        active = 1'b1;
        case (op_i)
            OP_ASR:  fill = x_i[DATA_W-1];
            OP_LSR:  fill = 1'b0;
            OP_RRC:  fill = cin_i;
            default: begin fill = 1'b0; active = 1'b0; end
        endcase
    end

    // Form the shifted word and the outgoing bit.
    always_comb begin
        if (active) begin
            res_o  = {fill, x_i[DATA_W-1:1]};
            cout_o = x_i[0];
        end else begin
            res_o  = '0;
            cout_o = 1'b0;
        end
    end

endmodule

// File: rtl/alu4_core.sv
`timescale 1ns/1ps
// alu4_core: top of the 4-bit ALU. Decodes the function code to a unit,
// selects that unit's result and carry, and derives the zero and negative flags.
// Purely combinational; assumes the surrounding datapath registers as needed.
module alu4_core
    import alu4_pkg::*;
#(
    parameter int unsigned DATA_W = 4
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic [3:0]        func_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              zero_o,
    output logic              neg_o
);

    alu_op_e           op;
    alu_unit_e         unit;
    logic [DATA_W-1:0] arith_res;
    logic              arith_c;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] shift_res;
    logic              shift_c;

    assign op = alu_op_e'(func_i);

    // Map each function code to the unit that serves it.
    always_comb begin
        case (op)
            OP_ADD, OP_SUB, OP_INC, OP_DEC:  unit = UNIT_ARITH;
            OP_XOR, OP_AND, OP_OR, OP_PASS:  unit = UNIT_LOGIC;
            OP_ASR, OP_LSR, OP_RRC:          unit = UNIT_SHIFT;
            default:                         unit = UNIT_NONE;
        endcase
    end

    alu4_arith #(.DATA_W(DATA_W)) u_arith (
        .op_i   (op),
        .x_i    (x_i),
        .y_i    (y_i),
        .sum_o  (arith_res),
        .cout_o (arith_c)
    );

    alu4_logic #(.DATA_W(DATA_W)) u_logic (
        .op_i   (op),
        .x_i    (x_i),
        .y_i    (y_i),
        .res_o  (logic_res)
    );

    alu4_shift #(.DATA_W(DATA_W)) u_shift (
        .op_i   (op),
        .x_i    (x_i),
        .cin_i  (carry_i),
        .res_o  (shift_res),
        .cout_o (shift_c)
    );

    // Steer the selected unit onto the outputs; unused codes give zero.
    always_comb begin
        case (unit)
            UNIT_ARITH: begin result_o = arith_res; carry_o = arith_c; end
            UNIT_LOGIC: begin result_o = logic_res; carry_o = 1'b0;    end
            UNIT_SHIFT: begin result_o = shift_res; carry_o = shift_c; end
            default:    begin result_o = '0;        carry_o = 1'b0;    end
        endcase
    end

    // Derive the status flags from the final result.
    always_comb begin
        zero_o = (result_o == '0);
        neg_o  = result_o[DATA_W-1];
    end

    // Port-level checks of the shift, pass-through and unused-code behaviour.
    always_comb begin
        if (!$isunknown({func_i, x_i, y_i, carry_i})) begin
            if (op == OP_PASS) begin
                assert_pass_y_R5: assert (result_o == y_i && !carry_o)
                    else $error("R5 pass-through mismatch");
            end
            if (op == OP_ASR) begin
                assert_asr_sign_R6: assert (result_o[DATA_W-1] == x_i[DATA_W-1] && carry_o == x_i[0])
                    else $error("R6 sign fill mismatch");
            end
            if (op == OP_LSR) begin
                assert_lsr_zero_R7: assert (!result_o[DATA_W-1] && carry_o == x_i[0])
                    else $error("R7 zero fill mismatch");
            end
            if (op == OP_RRC) begin
                assert_rrc_cin_R8: assert (result_o[DATA_W-1] == carry_i && carry_o == x_i[0])
                    else $error("R8 rotate through carry mismatch");
            end
            if (func_i > 4'b1010) begin
                assert_undef_zero_R9: assert (result_o == '0 && !carry_o)
                    else $error("R9 unused code not silent");
            end
            if (zero_o) begin
                assert_zero_flag_R10: assert (!neg_o)
                    else $error("R10 zero and negative both set");
            end
        end
    end

endmodule

// File: tb/alu4_core_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected items, the monitor pops and compares.
module alu4_core_tb;

    typedef struct {
        logic [3:0] res;
        logic       c;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] x = '0, y = '0, fn = '0;
    logic       cin = 1'b0;
    logic [3:0] res;
    logic       cout, zf, nf;
    int         n_checks = 0, n_fail = 0;
    bit         done = 0;
    exp_t       q[$];

    always #2 clk = ~clk;

    alu4_core u_dut (
        .x_i(x), .y_i(y), .func_i(fn), .carry_i(cin),
        .result_o(res), .carry_o(cout), .zero_o(zf), .neg_o(nf)
    );

    // Independent reference derived from the requirement text.
    function automatic exp_t model(int op, int a, int b, int ci);
        exp_t e;
        int   r = 0, c = 0;
        case (op)
            0:  begin r = a + b; c = (r > 15); end
            1:  begin r = a - b; c = (a >= b); end
            2:  begin r = a + 1; c = (a == 15); end
            3:  begin r = a - 1; c = (a != 0); end
            4:  r = a ^ b;
            5:  r = a & b;
            6:  r = a | b;
            7:  r = b;
            8:  begin r = (a >> 1) | (a & 8); c = a & 1; end
            9:  begin r = a >> 1; c = a & 1; end
            10: begin r = (a >> 1) | (ci << 3); c = a & 1; end
            default: begin r = 0; c = 0; end
        endcase
        e.res = 4'(r & 15);
        e.c   = c[0];
        case (op)
            0: e.tag = "R1"; 1: e.tag = "R2"; 2, 3: e.tag = "R3";
            4, 5, 6: e.tag = "R4"; 7: e.tag = "R5"; 8: e.tag = "R6";
            9: e.tag = "R7"; 10: e.tag = "R8"; default: e.tag = "R9";
        endcase
        if (ci != 0 && op != 10) e.tag = "R12";
        return e;
    endfunction

    task automatic push(int op, int a, int b, int ci, exp_t e);
        @(posedge clk);
        #1;
        fn = 4'(op); x = 4'(a); y = 4'(b); cin = ci[0];
        q.push_back(e);
    endtask

    task automatic drive(int op, int a, int b, int ci);
        push(op, a, b, ci, model(op, a, b, ci));
    endtask

    task automatic drive_exp(int op, int a, int b, int ci, int er, int ec, string tag);
        exp_t e;
        e.res = 4'(er); e.c = ec[0]; e.tag = tag;
        push(op, a, b, ci, e);
    endtask

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d (fn=%0d x=%0d y=%0d cin=%0d)",
                     tag, what, act, exp, fn, x, y, cin);
        end
    endtask

    // Monitor: compare outputs mid-cycle against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(res == e.res, e.tag, "result", res, e.res);
            check(cout == e.c, e.tag, "carry", cout, e.c);
            check(zf == (e.res == 4'd0), "R10", "zero", zf, e.res == 4'd0);
            check(nf == e.res[3], "R11", "negative", nf, e.res[3]);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // Reset-time state: all-zero inputs select add of zeros (R1, R10).
        #1;
        check(res == 4'd0 && !cout, "R1", "reset result", res, 0);
        check(zf == 1'b1, "R10", "reset zero", zf, 1);
        rst_n = 1'b1;

        // Directed carry and fill corners.
        drive_exp(0, 15, 1, 0, 0, 1, "R1");     // add wraps, carries
        drive_exp(0, 15, 1, 1, 0, 1, "R12");    // carry input ignored by add
        drive_exp(1, 0, 0, 0, 0, 1, "R2");      // 0-0: no borrow
        drive_exp(1, 0, 1, 0, 15, 0, "R2");     // 0-1: borrow
        drive_exp(1, 3, 5, 0, 14, 0, "R2");
        drive_exp(2, 15, 0, 0, 0, 1, "R3");     // increment wraps
        drive_exp(3, 0, 0, 0, 15, 0, "R3");     // decrement borrows
        drive_exp(3, 1, 0, 0, 0, 1, "R3");
        drive_exp(4, 12, 10, 0, 6, 0, "R4");
        drive_exp(7, 9, 6, 1, 6, 0, "R5");
        drive_exp(8, 9, 0, 0, 12, 1, "R6");     // 1001 -> 1100
        drive_exp(9, 9, 0, 0, 4, 1, "R7");      // 1001 -> 0100
        drive_exp(10, 9, 0, 1, 12, 1, "R8");    // 1001 with cin -> 1100
        drive_exp(10, 6, 0, 0, 3, 0, "R8");
        drive_exp(11, 15, 15, 1, 0, 0, "R9");
        drive_exp(15, 7, 9, 0, 0, 0, "R9");

        // Exhaustive sweep over codes, operands and carry input.
        for (int ci = 0; ci < 2; ci++)
            for (int op = 0; op < 16; op++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++)
                        drive(op, a, b, ci);

        repeat (3) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule